// File: doc/BRIEF.md
# Bang-Bang Loop Filter with Proportional Reset

This block is the digital loop filter of a bang-bang PLL. Once per reference cycle it takes a one-bit phase decision from the detector, offered as a beat on a valid/ready input. `in_up = 1` means the oscillator lags and must speed up. `in_up = 0` means it leads and must slow down. The filter keeps two registers. An integral register takes a small step (`alpha`) on every beat. A proportional register takes a large step (`beta`). It outputs their saturated sum as the oscillator control word.

While the filter is acquiring, the proportional steps build up, so the loop can pull the phase hard. When the detector polarity flips (lead then lag, or lag then lead), the phase has been crossed. The whole accumulated proportional code is then dropped, and the oscillator falls back to the frequency held by the integral register. Frequency correction then resumes from there. After a programmable number of consecutive flips, the phase error counts as small. A sticky tracking flag is then set, and the filter runs as a plain proportional-integral filter.

Back-pressure rules:
- `in_ready` is low while reset is asserted and for the first cycle after reset is released.
- After that, `in_ready` stays high and the block never stalls the detector.
- A beat is consumed on a rising edge where both `in_valid` and `in_ready` are high.
- The gains, centre code and settle count are plain control inputs, sampled on the edge that consumes a beat.

Top module: `bb_loop_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the integral register with `center`, clears the proportional register and the tracking flag, and drives `in_ready` low. `in_ready` rises on the first edge with `rst` low, and any beat offered while it is low is ignored.
- R2: Only consumed beats change the filter state: with no beat consumed, `ctrl_word` and `tracking` hold their values.
- R3: On each consumed beat, the integral register moves by +`alpha` when `in_up = 1` and by -`alpha` when `in_up = 0`, saturated to 0 .. 2^CW-1.
- R4: In acquisition (`tracking = 0`), a beat that is not a reversal adds +`beta` (`in_up = 1`) or -`beta` (`in_up = 0`) to the proportional register, saturated to -(2^CW-1) .. +(2^CW-1).
- R5: In acquisition, a reversal clears the proportional register to 0 while the integral step of that beat still applies. A reversal is a consumed beat whose `in_up` differs from that of the previous consumed beat. The first beat after reset is never a reversal.
- R6: In acquisition, consecutive reversals are counted, and a non-reversal beat restarts the count at zero. The count saturates at 2^RCW-1. A reversal that brings the count, including itself, to at least `settle_count` sets `tracking` (`settle_count = 0`: the first reversal sets it). `tracking` then stays high until reset.
- R7: In tracking, each beat loads the proportional register with exactly +`beta` (`in_up = 1`) or -`beta` (`in_up = 0`), with no accumulation and no clearing on reversals.
- R8: `ctrl_word` equals integral plus proportional, clamped to 0 .. 2^CW-1. It reflects a beat directly after the edge that consumed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A phase decision is offered |
| in_ready | output | 1 | The filter can consume a decision |
| in_up | input | 1 | Decision: 1 = lag (speed up), 0 = lead (slow down) |
| alpha | input | GW | Integral step size |
| beta | input | GW | Proportional step size |
| center | input | CW | Integral value loaded on reset |
| settle_count | input | RCW | Consecutive reversals needed to enter tracking |
| ctrl_word | output | CW | Oscillator control word |
| tracking | output | 1 | Sticky flag: plain PI operation |

## Verification
Each internal register fault shows at the ports on the edge of the beat that exposes it, because `ctrl_word` is combinational from the two code registers:
- A missed or spurious proportional clear shows as a jump of up to the accumulated code in the first cycle after a reversal.
- A wrong integral step shows as an `alpha`-sized offset that persists and grows with every beat.
- A reversal counter that fails to restart, or a tracking flag that sets early or late, shows on the `tracking` pin at the reversal where it should or should not rise. From then on, every beat gives a `ctrl_word` that differs by the accumulated-versus-single `beta` step.

The stimulus forces both saturation rails, interrupted reversal runs, a zero settle count, and live gain changes. A cycle-accurate model is compared against the ports after every edge.

// File: rtl/bblf_pkg.sv
package bblf_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

  typedef struct packed {
    logic fire;
    dir_e dir;
  } beat_t;
endpackage

// File: rtl/bblf_integ.sv
module bblf_integ
  import bblf_pkg::*;
#(
  parameter int CW = 10,
  parameter int GW = 6,
  parameter int SW = CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  beat_t                beat,
  input  logic [GW-1:0]        alpha,
  input  logic [CW-1:0]        center,
  output logic signed [SW-1:0] integ
);
  localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << CW) - 1);

  logic signed [SW-1:0] step, cand, nxt;

  always_comb begin
    step = $signed({{(SW-GW){1'b0}}, alpha});
    cand = (beat.dir == DIR_UP) ? integ + step : integ - step;
    if (cand > CODE_MAX)  nxt = CODE_MAX;
    else if (cand < 0)    nxt = '0;
    else                  nxt = cand;
  end

  always_ff @(posedge clk) begin
    if (rst)            integ <= $signed({{(SW-CW){1'b0}}, center});
    else if (beat.fire) integ <= nxt;
  end
endmodule

// File: rtl/bblf_prop.sv
module bblf_prop
  import bblf_pkg::*;
#(
  parameter int CW = 10,
  parameter int GW = 6,
  parameter int SW = CW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  beat_t                beat,
  input  logic                 clear,
  input  logic                 tracking,
  input  logic [GW-1:0]        beta,
  output logic signed [SW-1:0] prop
);
  localparam logic signed [SW-1:0] LIM = SW'((1 << CW) - 1);

  logic signed [SW-1:0] step, sstep, acc, acc_sat, nxt;

  always_comb begin
    step  = $signed({{(SW-GW){1'b0}}, beta});
    sstep = (beat.dir == DIR_UP) ? step : -step;
    acc   = prop + sstep;
    if (acc > LIM)        acc_sat = LIM;
    else if (acc < -LIM)  acc_sat = -LIM;
    else                  acc_sat = acc;
    if (tracking)         nxt = sstep;
    else if (clear)       nxt = '0;
    else                  nxt = acc_sat;
  end

  always_ff @(posedge clk) begin
    if (rst)            prop <= '0;
    else if (beat.fire) prop <= nxt;
  end
endmodule

// File: rtl/bblf_polarity.sv
module bblf_polarity
  import bblf_pkg::*;
#(
  parameter int RCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  beat_t          beat,
  input  logic [RCW-1:0] settle_count,
  output logic           reversal,
  output logic           tracking
);
  logic           seen;
  dir_e           last;
  logic [RCW-1:0] run, run_inc;

  assign reversal = beat.fire && seen && (beat.dir != last);
  assign run_inc  = (run == '1) ? run : run + RCW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      last     <= DIR_DOWN;
      run      <= '0;
      tracking <= 1'b0;
    end else if (beat.fire) begin
      seen <= 1'b1;
      last <= beat.dir;
      if (!tracking) begin
        if (reversal) begin
          run <= run_inc;
          if (run_inc >= settle_count) tracking <= 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bb_loop_filter.sv
module bb_loop_filter
  import bblf_pkg::*;
#(
  parameter int CW  = 10,
  parameter int GW  = 6,
  parameter int RCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_up,
  input  logic [GW-1:0]  alpha,
  input  logic [GW-1:0]  beta,
  input  logic [CW-1:0]  center,
  input  logic [RCW-1:0] settle_count,
  output logic [CW-1:0]  ctrl_word,
  output logic           tracking
);
  localparam int SW = CW + 2;
  localparam logic signed [SW:0] OUT_MAX = (SW+1)'((1 << CW) - 1);

  beat_t                beat;
  logic                 reversal;
  logic signed [SW-1:0] integ_q, prop_q;
  logic signed [SW:0]   sum;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign beat.fire = in_valid & in_ready;
  assign beat.dir  = in_up ? DIR_UP : DIR_DOWN;

  bblf_polarity #(.RCW(RCW)) u_pol (
    .clk(clk), .rst(rst), .beat(beat), .settle_count(settle_count),
    .reversal(reversal), .tracking(tracking)
  );

  bblf_integ #(.CW(CW), .GW(GW), .SW(SW)) u_int (
    .clk(clk), .rst(rst), .beat(beat), .alpha(alpha), .center(center),
    .integ(integ_q)
  );

  bblf_prop #(.CW(CW), .GW(GW), .SW(SW)) u_prop (
    .clk(clk), .rst(rst), .beat(beat), .clear(reversal & ~tracking),
    .tracking(tracking), .beta(beta), .prop(prop_q)
  );

  always_comb begin
    sum = {integ_q[SW-1], integ_q} + {prop_q[SW-1], prop_q};
    if (sum < 0)             ctrl_word = '0;
    else if (sum > OUT_MAX)  ctrl_word = OUT_MAX[CW-1:0];
    else                     ctrl_word = sum[CW-1:0];
  end
endmodule

// File: rtl/bblf_checker.sv
module bblf_checker #(
  parameter int CW = 10,
  parameter int GW = 6,
  parameter int SW = CW + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_up,
  input logic [GW-1:0]        beta,
  input logic [CW-1:0]        ctrl_word,
  input logic                 tracking,
  input logic                 reversal,
  input logic signed [SW-1:0] prop_q,
  input logic signed [SW-1:0] integ_q
);
  logic armed;
  logic signed [SW-1:0] beta_s;

  assign beta_s = $signed({{(SW-GW){1'b0}}, beta});

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> in_ready);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_valid && in_ready)) |-> ($stable(ctrl_word) && $stable(integ_q) && $stable(tracking)));

  assert_reversal_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && reversal && !tracking) |=> (prop_q == 0));

  assert_mode_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    tracking |=> tracking);

  assert_track_step_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && tracking) |=>
      (prop_q == ($past(in_up) ? $past(beta_s) : -$past(beta_s))));
endmodule

bind bb_loop_filter bblf_checker #(.CW(CW), .GW(GW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_up(in_up),
  .beta(beta), .ctrl_word(ctrl_word), .tracking(tracking), .reversal(reversal),
  .prop_q(prop_q), .integ_q(integ_q)
);

// File: tb/bb_loop_filter_test.sv
module bb_loop_filter_test;
  localparam int CLK_P = 10;
  localparam int CW = 10, GW = 6, RCW = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int RMAX = (1 << RCW) - 1;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst = 1'b1, in_valid = 1'b0, in_up = 1'b0, in_ready, tracking;
  logic [GW-1:0] alpha = '0, beta = '0;
  logic [CW-1:0] center = '0, ctrl_word;
  logic [RCW-1:0] settle_count = '0;

  bb_loop_filter #(.CW(CW), .GW(GW), .RCW(RCW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_up(in_up),
    .alpha(alpha), .beta(beta), .center(center), .settle_count(settle_count),
    .ctrl_word(ctrl_word), .tracking(tracking)
  );

  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0, chk = 0;
  int g_alpha = 2, g_beta = 20, g_center = 512, g_settle = 3;
  int m_integ = 0, m_prop = 0, m_run = 0;
  bit m_seen = 0, m_last = 0, m_trk = 0, m_rdy = 0;

  function automatic int clamp(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic compare();
    int exp_w;
    exp_w = clamp(m_integ + m_prop, 0, MAXC);
    n_vec++;
    if (int'(ctrl_word) != exp_w) begin
      n_bad++;
      $display("FAIL %s ctrl_word actual=%0d expected=%0d", tag, ctrl_word, exp_w);
    end
    n_vec++;
    if (tracking !== m_trk) begin
      n_bad++;
      $display("FAIL %s tracking actual=%0b expected=%0b", tag, tracking, m_trk);
    end
    n_vec++;
    if (in_ready !== m_rdy) begin
      n_bad++;
      $display("FAIL %s in_ready actual=%0b expected=%0b", tag, in_ready, m_rdy);
    end
  endtask

  task automatic model_step(bit r, bit v, bit u);
    int s;
    bit rev;
    if (r) begin
      m_integ = g_center; m_prop = 0; m_run = 0;
      m_seen = 0; m_last = 0; m_trk = 0; m_rdy = 0;
    end else begin
      if (v && m_rdy) begin
        s = u ? 1 : -1;
        rev = m_seen && (u != m_last);
        m_integ = clamp(m_integ + s * g_alpha, 0, MAXC);
        if (m_trk) m_prop = s * g_beta;
        else if (rev) begin
          m_prop = 0;
          m_run = (m_run == RMAX) ? RMAX : m_run + 1;
          if (m_run >= g_settle) m_trk = 1;
        end else begin
          m_prop = clamp(m_prop + s * g_beta, -MAXC, MAXC);
          m_run = 0;
        end
        m_last = u; m_seen = 1;
      end
      m_rdy = 1;
    end
  endtask

  task automatic apply(bit r, bit v, bit u);
    @(negedge clk);
    if (chk) compare();
    rst = r; in_valid = v; in_up = u;
    alpha = GW'(g_alpha); beta = GW'(g_beta);
    center = CW'(g_center); settle_count = RCW'(g_settle);
    model_step(r, v, u);
    chk = 1;
  endtask

  task automatic beats(int n, bit u);
    for (int i = 0; i < n; i++) apply(0, 1, u);
  endtask

  task automatic do_reset();
    apply(1, 1, 1);
    apply(1, 1, 0);
    apply(0, 1, 1);
  endtask

  initial begin
    tag = "R1 reset";
    do_reset();
    tag = "R2 idle";
    for (int i = 0; i < 4; i++) apply(0, 0, i[0]);
    tag = "R3 R4 R8 accumulate";
    beats(10, 1);
    tag = "R5 reversal clear";
    beats(1, 0);
    tag = "R6 interrupted run";
    beats(1, 0);
    beats(1, 1);
    beats(1, 1);
    beats(1, 0);
    beats(1, 1);
    tag = "R6 enter tracking";
    beats(1, 0);
    apply(0, 0, 0);
    tag = "R7 tracking";
    beats(5, 1);
    beats(3, 0);
    g_beta = 7;
    for (int i = 0; i < 6; i++) apply(0, 1, i[0]);
    tag = "R6 sticky";
    apply(0, 0, 1);
    apply(0, 0, 1);
    tag = "R3 R4 R8 high rail";
    g_center = 1000; g_alpha = 63; g_beta = 63; g_settle = 5;
    do_reset();
    beats(40, 1);
    tag = "R5 R8 clear at rail";
    beats(1, 0);
    tag = "R3 R4 R8 low rail";
    g_center = 5;
    do_reset();
    beats(30, 0);
    tag = "R6 zero settle";
    g_center = 300; g_alpha = 3; g_beta = 30; g_settle = 0;
    do_reset();
    beats(2, 1);
    beats(1, 0);
    beats(2, 0);
    tag = "R1 reset mid-run";
    apply(1, 1, 1);
    apply(0, 1, 1);
    tag = "R2 R3 R4 R5 R6 R7 R8 mixed";
    g_center = 512; g_alpha = 4; g_beta = 25; g_settle = 6;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 50) g_beta = ($urandom % 63) + 1;
      apply(0, ($urandom % 4) != 0, ($urandom % 3) != 0);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule